// File: doc/BRIEF.md
# Level-Sensitive Prioritized Interrupt Controller

This block collects a fixed set of level-sensitive interrupt lines and drives a single interrupt request toward a processor. Every source carries its own mask bit and a 4-bit priority. Each source is tracked as inactive, pending, active, or active while pending. Pending is not stored: it is taken from the live input level, so a line that is still high after service is simply seen as pending again.

Software works through a small register window. A read of the acknowledge register takes the most urgent eligible source and marks it active. An end-of-interrupt write lowers the running priority by popping one level off a small nesting stack. A deactivate write clears a source's active flag. A control bit selects whether end-of-interrupt also performs the deactivation. A read-only vector shows which sources are active.

A source whose priority is strictly more urgent than the current running priority interrupts the processor even while another handler runs, which gives nested service. If software delays the end-of-interrupt write, only more urgent sources can cut in.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: After reset, cpu_irq is 0, the active vector (offset 5) reads 0, the mask register (offset 1) reads all sources masked (bit i = 1 masks source i), and the control bit at offset 0 bit 0 reads 0.
- R2: A read at offset 2 returns the ID of the eligible source with the lowest priority value (0 most urgent) and marks it active. On a tie, the lowest ID wins. Source i's priority is nibble i mod 8 of the word at offset 8 + i/8.
- R3: A masked source never raises cpu_irq and is never returned by a read at offset 2, even while its line stays high.
- R4: A read at offset 2 returns 32'hFFFF_FFFF and changes no state when no unmasked, pending, non-active source is strictly more urgent than the running priority, or when the nesting stack is full.
- R5: With offset 0 bit 0 = 0, writing an ID to offset 3 pops the running priority and clears that source's active flag.
- R6: With offset 0 bit 0 = 1, writing an ID to offset 3 only pops the running priority. The source stays active until its ID is written to offset 4.
- R7: Pending follows the input level. An active source is not presented again while active. Once deactivated with its line still high, it is presented again.
- R8: A pending source preempts only when its priority value is strictly below the running priority. The running priority is the top of a stack of acknowledged priorities, and is below every real priority when the stack is empty.
- R9: Offset 5 reads one bit per source, with bit i set while source i is active.
- R10: cpu_irq is registered. It changes on the first clock edge after the input or state change that causes it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Register access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read strobe |
| irq_lines | input | NSRC | Level-sensitive interrupt inputs |
| cpu_irq | output | 1 | Registered interrupt request to the processor |

## Verification
A wrong active flag appears at the ports within one cycle. It either shows up in the active vector, or the source is returned (or withheld) by the next acknowledge read, and cpu_irq follows on the next edge. A corrupted nesting stack shows up as a wrong preemption decision: cpu_irq rises or stays low for a source of equal or higher priority value, and the acknowledge read returns a source or the all-ones value where the other was due. The bench fills the stack to its depth, and runs both end-of-interrupt modes with lines that stay high, so that these faults become visible within a few accesses.

// File: rtl/lic_pkg.sv
package lic_pkg;
  localparam int unsigned BUS_W  = 32;
  localparam int unsigned ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    OFS_CTRL   = 4'd0,
    OFS_MASK   = 4'd1,
    OFS_ACK    = 4'd2,
    OFS_EOI    = 4'd3,
    OFS_DEACT  = 4'd4,
    OFS_ACTIVE = 4'd5
  } lic_ofs_e;
endpackage

// File: rtl/lic_prio_stack.sv
module lic_prio_stack #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned PW    = 5,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [PW-1:0]    push_val,
  output logic [PW-1:0]    running,
  output logic             full,
  output logic [CNT_W-1:0] depth
);
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] IDLE_LVL = {1'b1, {(PW-1){1'b0}}};

  logic [PW-1:0]    lvl_q [DEPTH];
  logic [PW-1:0]    lvl_d [DEPTH];
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             upd_en;
  logic [IDX_W-1:0] wr_idx, top_idx;

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign wr_idx  = cnt_q[IDX_W-1:0];
  assign top_idx = IDX_W'(cnt_q - 1'b1);
  assign running = (cnt_q == '0) ? IDLE_LVL : lvl_q[top_idx];
  assign depth   = cnt_q;
  assign upd_en  = push | pop;

  always_comb begin
    lvl_d = lvl_q;
    cnt_d = cnt_q;
    if (push && !full) begin
      lvl_d[wr_idx] = push_val;
      cnt_d         = cnt_q + 1'b1;
    end else if (pop && (cnt_q != '0)) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) lvl_q[i] <= '0;
    end else if (upd_en) begin
      cnt_q <= cnt_d;
      lvl_q <= lvl_d;
    end
  end
endmodule

// File: rtl/lic_src_bank.sv
module lic_src_bank #(
  parameter int unsigned NSRC = 16,
  parameter int unsigned ID_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] lines,
  input  logic [NSRC-1:0] mask,
  input  logic            set_en,
  input  logic [ID_W-1:0] set_id,
  input  logic            clr_en,
  input  logic [ID_W-1:0] clr_id,
  output logic [NSRC-1:0] active,
  output logic [NSRC-1:0] eligible
);
  for (genvar g = 0; g < NSRC; g++) begin : g_src
    logic hit_set, hit_clr, act_d, act_q;

    assign hit_set = set_en && (set_id == ID_W'(g));
    assign hit_clr = clr_en && (clr_id == ID_W'(g));
    assign act_d   = hit_set | (act_q & ~hit_clr);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                act_q <= 1'b0;
      else if (hit_set | hit_clr) act_q <= act_d;
    end

    assign active[g]   = act_q;
    assign eligible[g] = lines[g] & ~mask[g] & ~act_q;
  end
endmodule

// File: rtl/lic_arbiter.sv
module lic_arbiter #(
  parameter int unsigned NSRC   = 16,
  parameter int unsigned PRIO_W = 4,
  parameter int unsigned ID_W   = 4
) (
  input  logic [NSRC-1:0]        eligible,
  input  logic [NSRC*PRIO_W-1:0] prio_flat,
  output logic                   found,
  output logic [ID_W-1:0]        best_id,
  output logic [PRIO_W-1:0]      best_prio
);
  always_comb begin
    found     = 1'b0;
    best_id   = '0;
    best_prio = '1;
    for (int i = 0; i < NSRC; i++) begin
      if (eligible[i] && (!found || (prio_flat[i*PRIO_W +: PRIO_W] < best_prio))) begin
        found     = 1'b1;
        best_id   = ID_W'(i);
        best_prio = prio_flat[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl
  import lic_pkg::*;
#(
  parameter int unsigned NSRC       = 16,
  parameter int unsigned PRIO_W     = 4,
  parameter int unsigned NEST_DEPTH = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [BUS_W-1:0]    bus_wdata,
  output logic [BUS_W-1:0]    bus_rdata,
  input  logic [NSRC-1:0]     irq_lines,
  output logic                cpu_irq
);
  localparam int unsigned ID_W       = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam int unsigned RUN_W      = PRIO_W + 1;
  localparam int unsigned PRIO_BITS  = NSRC * PRIO_W;
  localparam int unsigned PRIO_WORDS = (PRIO_BITS + BUS_W - 1) / BUS_W;
  localparam int unsigned DEPTH_W    = $clog2(NEST_DEPTH + 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign srst_n = rst_pipe_q[1];

  // access decode
  logic rd_en, wr_en, ack_rd, eoi_wr, deact_wr, ctrl_wr, mask_wr, prio_sel, id_ok;
  logic [2:0]      prio_word;
  logic [ID_W-1:0] wr_id;

  assign rd_en     = bus_sel & ~bus_wr;
  assign wr_en     = bus_sel & bus_wr;
  assign prio_sel  = bus_addr[3];
  assign prio_word = bus_addr[2:0];
  assign ack_rd    = rd_en && (bus_addr == OFS_ACK);
  assign eoi_wr    = wr_en && (bus_addr == OFS_EOI);
  assign deact_wr  = wr_en && (bus_addr == OFS_DEACT);
  assign ctrl_wr   = wr_en && (bus_addr == OFS_CTRL);
  assign mask_wr   = wr_en && (bus_addr == OFS_MASK);
  assign id_ok     = (bus_wdata < BUS_W'(NSRC));
  assign wr_id     = bus_wdata[ID_W-1:0];

  // configuration registers
  logic                 split_q, split_d;
  logic [NSRC-1:0]      mask_q, mask_d;
  logic [PRIO_BITS-1:0] prio_q, prio_d;
  logic                 cfg_en;

  assign cfg_en = ctrl_wr | mask_wr | (wr_en & prio_sel);

  always_comb begin
    split_d = split_q;
    mask_d  = mask_q;
    prio_d  = prio_q;
    if (ctrl_wr) split_d = bus_wdata[0];
    if (mask_wr) mask_d  = bus_wdata[NSRC-1:0];
    for (int w = 0; w < PRIO_WORDS; w++) begin
      if (wr_en && prio_sel && (prio_word == 3'(w))) begin
        for (int b = 0; b < BUS_W; b++) begin
          if (w * BUS_W + b < PRIO_BITS) prio_d[w*BUS_W + b] = bus_wdata[b];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      split_q <= 1'b0;
      mask_q  <= '1;
      prio_q  <= '0;
    end else if (cfg_en) begin
      split_q <= split_d;
      mask_q  <= mask_d;
      prio_q  <= prio_d;
    end
  end

  // per-source state, selection and nesting
  logic [NSRC-1:0]    active_vec, eligible_vec;
  logic               found, present, grant, stk_full;
  logic [ID_W-1:0]    best_id;
  logic [PRIO_W-1:0]  best_prio;
  logic [RUN_W-1:0]   running;
  logic [DEPTH_W-1:0] stack_depth;
  logic               clr_en;

  assign present = found && ({1'b0, best_prio} < running) && !stk_full;
  assign grant   = ack_rd && present;
  assign clr_en  = id_ok && (deact_wr || (eoi_wr && !split_q));

  lic_src_bank #(.NSRC(NSRC), .ID_W(ID_W)) u_bank (
    .clk      (clk),
    .rst_n    (srst_n),
    .lines    (irq_lines),
    .mask     (mask_q),
    .set_en   (grant),
    .set_id   (best_id),
    .clr_en   (clr_en),
    .clr_id   (wr_id),
    .active   (active_vec),
    .eligible (eligible_vec)
  );

  lic_arbiter #(.NSRC(NSRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_arb (
    .eligible  (eligible_vec),
    .prio_flat (prio_q),
    .found     (found),
    .best_id   (best_id),
    .best_prio (best_prio)
  );

  lic_prio_stack #(.DEPTH(NEST_DEPTH), .PW(RUN_W), .CNT_W(DEPTH_W)) u_stack (
    .clk      (clk),
    .rst_n    (srst_n),
    .push     (grant),
    .pop      (eoi_wr && id_ok),
    .push_val ({1'b0, best_prio}),
    .running  (running),
    .full     (stk_full),
    .depth    (stack_depth)
  );

  // registered request
  logic irq_q;
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) irq_q <= 1'b0;
    else         irq_q <= present;
  end
  assign cpu_irq = irq_q;

  // read mux
  logic [PRIO_WORDS*BUS_W-1:0] prio_pad;
  assign prio_pad = (PRIO_WORDS*BUS_W)'(prio_q);

  always_comb begin
    bus_rdata = '0;
    if (rd_en) begin
      if (prio_sel) begin
        for (int w = 0; w < PRIO_WORDS; w++) begin
          if (prio_word == 3'(w)) bus_rdata = prio_pad[w*BUS_W +: BUS_W];
        end
      end else begin
        case (bus_addr)
          OFS_CTRL:   bus_rdata = BUS_W'(split_q);
          OFS_MASK:   bus_rdata = BUS_W'(mask_q);
          OFS_ACK:    bus_rdata = present ? BUS_W'(best_id) : '1;
          OFS_ACTIVE: bus_rdata = BUS_W'(active_vec);
          default:    bus_rdata = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/lic_checker.sv
module lic_checker #(
  parameter int unsigned NSRC    = 16,
  parameter int unsigned ID_W    = 4,
  parameter int unsigned DEPTH   = 4,
  parameter int unsigned DEPTH_W = 3
) (
  input logic               clk,
  input logic               srst_n,
  input logic               bus_sel,
  input logic               bus_wr,
  input logic [3:0]         bus_addr,
  input logic [31:0]        bus_wdata,
  input logic [31:0]        bus_rdata,
  input logic [NSRC-1:0]    irq_lines,
  input logic               cpu_irq,
  input logic [NSRC-1:0]    active,
  input logic [NSRC-1:0]    mask,
  input logic               split,
  input logic [DEPTH_W-1:0] depth
);
  logic ack_rd, eoi_wr, deact_wr, id_ok;
  assign ack_rd   = bus_sel && !bus_wr && (bus_addr == 4'd2);
  assign eoi_wr   = bus_sel && bus_wr && (bus_addr == 4'd3);
  assign deact_wr = bus_sel && bus_wr && (bus_addr == 4'd4);
  assign id_ok    = (bus_wdata < 32'(NSRC));

  // R2
  ack_marks_active_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (ack_rd && bus_rdata != '1) |=> active[$past(bus_rdata[ID_W-1:0])]);

  // R4
  spurious_no_change_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (ack_rd && bus_rdata == '1) |=> (active == $past(active)));

  // R3
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!srst_n)
    ($past((irq_lines & ~mask) == '0)) |-> !cpu_irq);

  // R5
  eoi_joint_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (eoi_wr && id_ok && !split) |=> !active[$past(bus_wdata[ID_W-1:0])]);

  // R6
  eoi_split_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (eoi_wr && id_ok && split) |=>
      (active[$past(bus_wdata[ID_W-1:0])] == $past(active[bus_wdata[ID_W-1:0]])));

  // R6
  deact_clears_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (deact_wr && id_ok) |=> !active[$past(bus_wdata[ID_W-1:0])]);

  // R8
  nest_bound_chk: assert property (@(posedge clk) disable iff (!srst_n)
    depth <= DEPTH_W'(DEPTH));
endmodule

bind lvl_irq_ctrl lic_checker #(
  .NSRC(NSRC), .ID_W(ID_W), .DEPTH(NEST_DEPTH), .DEPTH_W(DEPTH_W)
) u_chk (
  .clk       (clk),
  .srst_n    (srst_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .irq_lines (irq_lines),
  .cpu_irq   (cpu_irq),
  .active    (active_vec),
  .mask      (mask_q),
  .split     (split_q),
  .depth     (stack_depth)
);

// File: tb/lvl_irq_ctrl_tb.sv
module lvl_irq_ctrl_tb;
  localparam int NSRC = 16;
  localparam logic [31:0] SPUR = 32'hFFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [NSRC-1:0] irq_lines;
  logic        cpu_irq;

  always #5 clk = ~clk;

  lvl_irq_ctrl #(.NSRC(NSRC), .PRIO_W(4), .NEST_DEPTH(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_lines(irq_lines), .cpu_irq(cpu_irq)
  );

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  exp_t        cur;
  logic [31:0] act;
  event        sample_ev;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  // monitor: pops expected items and compares with the ports
  initial begin
    forever begin
      @(sample_ev);
      while (sb_q.size() > 0) begin
        cur = sb_q.pop_front();
        act = cur.is_irq ? 32'(cpu_irq) : bus_rdata;
        checks++;
        if (act !== cur.exp) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", cur.tag, act, cur.exp);
        end
      end
    end
  end

  task automatic expect_item(input bit is_irq, input logic [31:0] exp, input string tag);
    exp_t e;
    e.is_irq = is_irq;
    e.exp    = exp;
    e.tag    = tag;
    sb_q.push_back(e);
    -> sample_ev;
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #2;
    expect_item(1'b0, exp, tag);
    @(posedge clk); #1;
    bus_sel = 1'b0;
  endtask

  task automatic set_lines(input logic [NSRC-1:0] v);
    @(negedge clk);
    irq_lines = v;
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    @(negedge clk);
    @(negedge clk);
    #2;
    expect_item(1'b1, 32'(exp), tag);
  endtask

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0;
    bus_wdata = '0; irq_lines = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1 reset state
    bus_read(4'd5, 32'h0, "R1 active after reset");
    bus_read(4'd1, 32'h0000_FFFF, "R1 mask after reset");
    bus_read(4'd0, 32'h0, "R1 ctrl after reset");
    chk_irq(1'b0, "R1 irq after reset");

    // R3 masked lines stay quiet
    set_lines(16'hFFFF);
    chk_irq(1'b0, "R3 masked lines no irq");
    bus_read(4'd2, SPUR, "R3 masked not acked");
    set_lines(16'h0000);

    // priorities: src0=5 src1=3 src2=3 src3=7 src4..7=8, src8=1 src9..15=8
    bus_write(4'd8, 32'h8888_7335);
    bus_write(4'd9, 32'h8888_8881);
    bus_read(4'd8, 32'h8888_7335, "R2 priority word readback");
    bus_write(4'd1, 32'h0);

    // R10 request is registered
    @(negedge clk);
    irq_lines = 16'h000E;
    #2 expect_item(1'b1, 32'd0, "R10 irq not yet raised");
    chk_irq(1'b1, "R10 irq raised after edge");

    // R2 tie on priority 3 -> lowest ID
    bus_read(4'd2, 32'd1, "R2 ack tie lowest id");
    chk_irq(1'b0, "R8 equal priority no preempt");
    bus_read(4'd2, SPUR, "R4 nothing beats running");
    bus_read(4'd5, 32'h0000_0002, "R9 active vector");

    // R8 more urgent source preempts
    set_lines(16'h010E);
    chk_irq(1'b1, "R8 urgent preempts");
    bus_read(4'd2, 32'd8, "R8 ack nested");
    bus_read(4'd5, 32'h0000_0102, "R9 two active");

    // R5 joint EOI, line still high refires
    bus_write(4'd3, 32'd8);
    bus_read(4'd5, 32'h0000_0002, "R5 eoi deactivates");
    chk_irq(1'b1, "R7 high line refires");
    set_lines(16'h000E);
    chk_irq(1'b0, "R8 back at running 3");

    // R6 split mode
    bus_write(4'd0, 32'd1);
    bus_write(4'd3, 32'd1);
    bus_read(4'd5, 32'h0000_0002, "R6 split eoi keeps active");
    bus_read(4'd2, 32'd2, "R7 active source skipped");
    bus_write(4'd4, 32'd1);
    bus_read(4'd5, 32'h0000_0004, "R6 deactivate clears");
    chk_irq(1'b0, "R8 deactivated equal prio waits");
    bus_write(4'd3, 32'd2);
    chk_irq(1'b1, "R7 refire after drop");
    bus_read(4'd2, 32'd1, "R7 re-acked after deactivate");
    bus_read(4'd5, 32'h0000_0006, "R9 active 1 and 2");

    // cleanup
    bus_write(4'd3, 32'd1);
    bus_write(4'd4, 32'd1);
    bus_write(4'd4, 32'd2);
    set_lines(16'h0000);
    bus_read(4'd5, 32'h0, "R6 all deactivated");

    // R4 nesting stack fills at depth 4
    set_lines(16'h0010);
    chk_irq(1'b1, "R8 idle preempt");
    bus_read(4'd2, 32'd4, "R8 nest level 1");
    set_lines(16'h0018);
    bus_read(4'd2, 32'd3, "R8 nest level 2");
    set_lines(16'h0019);
    bus_read(4'd2, 32'd0, "R8 nest level 3");
    set_lines(16'h001B);
    bus_read(4'd2, 32'd1, "R8 nest level 4");
    set_lines(16'h011B);
    chk_irq(1'b0, "R4 stack full no irq");
    bus_read(4'd2, SPUR, "R4 stack full spurious");
    bus_write(4'd3, 32'd1);
    chk_irq(1'b1, "R8 pop re-enables preempt");
    bus_read(4'd2, 32'd8, "R8 ack after pop");
    bus_read(4'd5, 32'h0000_011B, "R9 final active");

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule